// File: doc/BRIEF.md
# Transmit Channel-Status, User and Validity Bit Formatter

This block supplies the three per-subframe side bits (channel status C, user U, validity V) that a digital audio transmitter inserts into each subframe of an AES3 / IEC 60958 stream. It follows a left/right clock that is synchronous to the system clock. Each edge of that clock starts a subframe: a rising edge starts the left subframe, and with it a new frame. A falling edge starts the right subframe. On every edge the block registers fresh C, U and V values. It holds them unchanged until the next edge, so the downstream encoder sees bits that stay aligned with the subframe it is building.

Two sourcing modes are offered. In serial mode all three bits are sampled from serial inputs at each left/right-clock edge. In pin mode U and V are still sampled serially. C comes from a consumer-format channel-status block that the block assembles from four static control inputs and a fixed category code that marks a sample-rate converter. In pin mode both subframes of a frame carry the same channel-status bit, selected by the frame number.

The block counts frames through the 192-frame channel-status block. A direction input selects how the block-start marker behaves. In output direction the marker is produced internally and is high for both subframes of frame 0. In input direction a pulse on the block-start input forces the next frame to be frame 0.

Top module: `aes_cuv_fmt`

## Requirements
- R1: While reset is active and after it is released, c_out, u_out, v_out and blk_out are 0 and the frame count is 0. The first left subframe after reset is frame 0.
- R2: The four outputs change only in the clock cycle that registers a left/right-clock edge. Input changes between edges have no effect on the outputs.
- R3: At every left/right-clock edge, rising or falling, u_out and v_out take the values present on u_in and v_in in that cycle.
- R4: With serial_mode = 1, c_out takes the value on c_in at every left/right-clock edge.
- R5: With serial_mode = 0, c_out is channel-status bit n of the pin-built block, where n is the current frame number (0..191). Both the left and the right subframe of a frame carry the same bit. A rising edge starts a new frame.
- R6: In the pin-built block, bit 0 = 0 (consumer), bit 1 = non_audio, bit 2 = copy_en, bit 3 = emph_on, and bits 4 to 7 are 0.
- R7: In the pin-built block, bits 8 to 14 hold the category code 0101100b sent least significant bit first, so bits 10, 11 and 13 are 1 and bits 8, 9, 12 and 14 are 0. Bit 15 = orig_flag. Bits 16 to 191 are 0.
- R8: The frame number advances by one at each rising edge and wraps from 191 to 0. With blk_dir_out = 1, blk_out is 1 exactly for both subframes of frame 0.
- R9: With blk_dir_out = 0, blk_out is 0 from the next left/right-clock edge on. A blk_in pulse between rising edges is held and makes the next rising edge start frame 0. With blk_dir_out = 1, blk_in is ignored.
- R10: A blk_in pulse in the same cycle as a rising edge, with blk_dir_out = 0, makes that very frame frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_clk | input | 1 | Left/right clock, synchronous to clk; high marks the left subframe |
| serial_mode | input | 1 | 1: C taken serially; 0: C built from pins |
| c_in | input | 1 | Serial channel-status bit |
| u_in | input | 1 | Serial user bit |
| v_in | input | 1 | Serial validity bit |
| copy_en | input | 1 | Copy-permitted flag for the pin-built block |
| orig_flag | input | 1 | Original/generation flag for the pin-built block |
| emph_on | input | 1 | Pre-emphasis active flag for the pin-built block |
| non_audio | input | 1 | Non-audio content flag for the pin-built block |
| blk_dir_out | input | 1 | 1: block start generated internally; 0: taken from blk_in |
| blk_in | input | 1 | Block-start resynchronisation pulse |
| c_out | output | 1 | Channel-status bit for the current subframe |
| u_out | output | 1 | User bit for the current subframe |
| v_out | output | 1 | Validity bit for the current subframe |
| blk_out | output | 1 | Block-start marker, high during frame 0 |

## Verification
A resynchronisation pulse on blk_in and a frame boundary (a rising left/right-clock edge) can land in the same cycle. The pulse must then act on that boundary and not be deferred to the next one. The bench drives blk_in high in exactly the cycle of the lr_clk rise and expects frame 0 at once. It also raises the pulse together with a falling edge and expects frame 0 only at the following rise. A scoreboard follows the frame number on its own and compares every registered subframe, including the held cycles in which the serial inputs are deliberately inverted.

// File: rtl/cuv_pkg.sv
package cuv_pkg;

  typedef struct packed {
    logic c;
    logic u;
    logic v;
    logic blk;
  } cuv_t;

  // Consumer channel-status bit for a given frame index, built from pins.
  function automatic logic cs_pin_bit(input logic [15:0] idx, input logic [6:0] cat,
                                      input logic copy_en, input logic orig_flag,
                                      input logic emph_on, input logic non_audio);
    logic b;
    b = 1'b0;
    if (idx == 16'd1)      b = non_audio;
    else if (idx == 16'd2) b = copy_en;
    else if (idx == 16'd3) b = emph_on;
    else if (idx >= 16'd8 && idx <= 16'd14) b = cat[3'(idx - 16'd8)];
    else if (idx == 16'd15) b = orig_flag;
    return b;
  endfunction

endpackage

// File: rtl/cuv_edge.sv
module cuv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_clk,
  output logic rise,
  output logic any_edge
);
  logic lr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lr_q <= 1'b0;
    else        lr_q <= lr_clk;
  end

  assign rise     = lr_clk & ~lr_q;
  assign any_edge = lr_clk ^ lr_q;
endmodule

// File: rtl/cuv_blkcnt.sv
module cuv_blkcnt #(
  parameter int FRAMES = 192,
  localparam int CW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          blk_dir_out,
  input  logic          blk_in,
  output logic [CW-1:0] frame_sel
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          started_q, started_d;
  logic          pend_q, pend_d;
  logic          sync_now;

  assign sync_now = ~blk_dir_out & (pend_q | blk_in);

  always_comb begin
    frame_sel = cnt_q;
    if (rise) begin
      if (sync_now || !started_q)        frame_sel = '0;
      else if (cnt_q == CW'(FRAMES - 1)) frame_sel = '0;
      else                               frame_sel = cnt_q + CW'(1);
    end
  end

  always_comb begin
    cnt_d     = cnt_q;
    started_d = started_q;
    pend_d    = pend_q;
    if (rise) begin
      cnt_d     = frame_sel;
      started_d = 1'b1;
      pend_d    = 1'b0;
    end else if (!blk_dir_out && blk_in) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      started_q <= started_d;
      pend_q    <= pend_d;
    end
  end
endmodule

// File: rtl/cuv_csgen.sv
module cuv_csgen #(
  parameter int         FRAMES  = 192,
  parameter logic [6:0] CAT_CODE = 7'b0101100,
  localparam int CW = $clog2(FRAMES)
) (
  input  logic [CW-1:0] idx,
  input  logic          copy_en,
  input  logic          orig_flag,
  input  logic          emph_on,
  input  logic          non_audio,
  output logic          cs_bit
);
  import cuv_pkg::*;

  assign cs_bit = cs_pin_bit(16'(idx), CAT_CODE, copy_en, orig_flag, emph_on, non_audio);
endmodule

// File: rtl/aes_cuv_fmt.sv
module aes_cuv_fmt #(
  parameter int         FRAMES   = 192,
  parameter logic [6:0] CAT_CODE = 7'b0101100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_clk,
  input  logic serial_mode,
  input  logic c_in,
  input  logic u_in,
  input  logic v_in,
  input  logic copy_en,
  input  logic orig_flag,
  input  logic emph_on,
  input  logic non_audio,
  input  logic blk_dir_out,
  input  logic blk_in,
  output logic c_out,
  output logic u_out,
  output logic v_out,
  output logic blk_out
);
  import cuv_pkg::*;
  localparam int CW = $clog2(FRAMES);

  logic          rise, any_edge, cs_bit;
  logic [CW-1:0] frame_sel;
  cuv_t          out_q, out_d;

  cuv_edge i_edge (
    .clk(clk), .rst_n(rst_n), .lr_clk(lr_clk), .rise(rise), .any_edge(any_edge)
  );

  cuv_blkcnt #(.FRAMES(FRAMES)) i_blkcnt (
    .clk(clk), .rst_n(rst_n), .rise(rise), .blk_dir_out(blk_dir_out),
    .blk_in(blk_in), .frame_sel(frame_sel)
  );

  cuv_csgen #(.FRAMES(FRAMES), .CAT_CODE(CAT_CODE)) i_csgen (
    .idx(frame_sel), .copy_en(copy_en), .orig_flag(orig_flag),
    .emph_on(emph_on), .non_audio(non_audio), .cs_bit(cs_bit)
  );

  always_comb begin
    out_d = out_q;
    if (any_edge) begin
      out_d.u   = u_in;
      out_d.v   = v_in;
      out_d.c   = serial_mode ? c_in : cs_bit;
      out_d.blk = blk_dir_out & (frame_sel == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign c_out   = out_q.c;
  assign u_out   = out_q.u;
  assign v_out   = out_q.v;
  assign blk_out = out_q.blk;
endmodule

// File: rtl/cuv_fmt_chk.sv
module cuv_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic lr_clk,
  input logic serial_mode,
  input logic c_in,
  input logic u_in,
  input logic v_in,
  input logic blk_dir_out,
  input logic c_out,
  input logic u_out,
  input logic v_out,
  input logic blk_out
);
  logic lr_prev;
  logic edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lr_prev <= 1'b0;
    else        lr_prev <= lr_clk;
  end

  assign edge_seen = lr_clk ^ lr_prev;

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert ({c_out, u_out, v_out, blk_out} == 4'b0)
        else $error("outputs not cleared in reset");
    end
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_seen |=> $stable({c_out, u_out, v_out, blk_out}));

  // R3
  uv_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> (u_out == $past(u_in)) && (v_out == $past(v_in)));

  // R4
  serial_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && serial_mode) |=> c_out == $past(c_in));

  // R8
  blk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_out) |-> ($past(lr_clk) && !$past(lr_clk, 2)));

  // R8
  blk_one_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && lr_clk && blk_out && blk_dir_out) |=> !blk_out);

  // R9
  blk_in_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !blk_dir_out) |=> !blk_out);
endmodule

bind aes_cuv_fmt cuv_fmt_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lr_clk(lr_clk), .serial_mode(serial_mode),
  .c_in(c_in), .u_in(u_in), .v_in(v_in), .blk_dir_out(blk_dir_out),
  .c_out(c_out), .u_out(u_out), .v_out(v_out), .blk_out(blk_out)
);

// File: tb/test_aes_cuv_fmt.sv
module test_aes_cuv_fmt;
  logic clk = 1'b0;
  logic rst_n;
  logic lr_clk, serial_mode, c_in, u_in, v_in;
  logic copy_en, orig_flag, emph_on, non_audio, blk_dir_out, blk_in;
  logic c_out, u_out, v_out, blk_out;

  aes_cuv_fmt i_aes_cuv_fmt (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [3:0] val;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  int   frame  = 0;
  bit   first  = 1;
  bit   pend   = 0;
  string tag   = "R1";

  // Expected channel-status bit, written from R5..R7.
  function automatic logic ref_cs(input int f);
    case (f)
      1:          return non_audio;
      2:          return copy_en;
      3:          return emph_on;
      10, 11, 13: return 1'b1;
      15:         return orig_flag;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic push(input logic [3:0] v);
    exp_t e;
    e.val = v;
    e.req = tag;
    q.push_back(e);
  endtask

  task automatic sub(input logic left, input logic cb, input logic ub, input logic vb,
                     input bit pulse_edge, input bit pulse_mid);
    logic [3:0] e;
    @(negedge clk);
    lr_clk = left; c_in = cb; u_in = ub; v_in = vb; blk_in = pulse_edge;
    if (left) begin
      if (first || (!blk_dir_out && (pend || pulse_edge))) frame = 0;
      else frame = (frame + 1) % 192;
      first = 0;
      pend  = 0;
    end else if (pulse_edge && !blk_dir_out) begin
      pend = 1;
    end
    e = {serial_mode ? cb : ref_cs(frame), ub, vb, blk_dir_out && (frame == 0)};
    @(posedge clk); push(e);
    @(negedge clk);
    c_in = ~cb; u_in = ~ub; v_in = ~vb; blk_in = pulse_mid;
    if (pulse_mid && !blk_dir_out) pend = 1;
    @(posedge clk); push(e);
    @(negedge clk); blk_in = 1'b0;
    @(posedge clk); push(e);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      sub(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 0, 0);
      sub(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 0, 0);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if ({c_out, u_out, v_out, blk_out} !== it.val) begin
        errors++;
        $display("FAIL %s frame=%0d {c,u,v,blk} actual=%b expected=%b",
                 it.req, frame, {c_out, u_out, v_out, blk_out}, it.val);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; lr_clk = 0; serial_mode = 0; c_in = 0; u_in = 0; v_in = 0;
    copy_en = 1; orig_flag = 1; emph_on = 1; non_audio = 1; blk_dir_out = 1; blk_in = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({c_out, u_out, v_out, blk_out} !== 4'b0) begin
      errors++;
      $display("FAIL R1 in reset actual=%b expected=0000", {c_out, u_out, v_out, blk_out});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if ({c_out, u_out, v_out, blk_out} !== 4'b0) begin
      errors++;
      $display("FAIL R1 after release actual=%b expected=0000", {c_out, u_out, v_out, blk_out});
    end

    // R1/R8: first frame after reset is frame 0, blk_out high
    tag = "R1"; frames(1);
    // R5 R6 R7 R8: full block with all pins set, then wrap
    tag = "R5_R6_R7_R8"; frames(195);
    // R6 R7: pins cleared, full block
    copy_en = 0; orig_flag = 0; emph_on = 0; non_audio = 0;
    tag = "R6_R7"; frames(192);
    // R4 R2 R3: serial mode
    serial_mode = 1; tag = "R4"; frames(24);
    serial_mode = 0;
    // R9: blk_in ignored in output direction
    tag = "R9"; sub(1, 0, 1, 0, 0, 0); sub(0, 1, 0, 1, 0, 1); frames(2);
    // R9: input direction, mid-frame pulse
    blk_dir_out = 0; tag = "R9"; frames(3);
    sub(1, 0, 0, 1, 0, 1); sub(0, 1, 1, 0, 0, 0); frames(3);
    // R10: pulse coincident with rising edge
    tag = "R10"; frames(2);
    sub(1, 1, 0, 0, 1, 0); sub(0, 0, 1, 1, 0, 0); frames(2);
    // R9: pulse coincident with falling edge applies at next rise
    tag = "R9"; sub(1, 0, 0, 0, 0, 0); sub(0, 1, 1, 1, 1, 0); frames(2);
    // R8: back to output direction, count continues
    blk_dir_out = 1; tag = "R8"; frames(192);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule